// File: doc/BRIEF.md
# Local Interrupt Priority Resolver

This block keeps the per-core interrupt bookkeeping for 256 interrupt vectors. It holds two 256-entry bitmaps: one for requested vectors and one for in-service vectors. It also takes in a task priority value. From these it continuously forms the processor priority and decides whether the highest requested vector may be handed to the core. Each vector lives in bit `vector % 32` of 32-bit bitmap word `vector / 32`. The highest set vector is found by a two-level priority encoder that reports a separate hit flag.

Requests arrive on a valid/ready stream. That stream never applies back-pressure: `req_ready` is held high. A request whose vector is below 16 is dropped. Delivery is a second valid/ready stream. `dlv_valid` holds while a vector is deliverable, and `dlv_vector` names that vector. When the core raises `dlv_ready` in a cycle where `dlv_valid` is high, the vector leaves the request map and enters the in-service map at that clock edge. A ready without a valid transfers nothing. An end-of-service strobe retires the highest in-service vector.

A separate combinational output tells the core whether to accept an interrupt from the legacy controller. This output depends on the core being the bootstrap core, the hardware enable, and the line-0 local vector entry.

Top module: `lapic_prio_resolver`

## Requirements
- R1: While `rst_n` is low, and after it is released, both bitmaps are empty, `irr_pending` is 0 and `dlv_valid` is 0. `ppr` then equals `tpr`.
- R2: `req_ready` is always 1. A request with `req_vector` ≥ 16 sets that vector's request bit at the clock edge. A request with a vector in 0..15 changes nothing, and `irr_pending` stays as it was.
- R3: Let S be the highest in-service vector, or 0 when nothing is in service. If `tpr[7:4]` ≥ `S[7:4]`, then `ppr` = `tpr`. Otherwise `ppr` = {`S[7:4]`, 4'h0}.
- R4: `dlv_valid` is 1 exactly when three conditions hold: the block is enabled, some request bit is set, and {H[7:4], 4'h0} > `ppr`, where H is the highest requested vector. `dlv_vector` = H. This holds whichever 32-bit word H falls in.
- R5: The block is enabled only when both `sw_enable` and `hw_enable` are 1. Otherwise `dlv_valid` is 0.
- R6: When `dlv_valid` and `dlv_ready` are both 1 at a clock edge, the vector's request bit clears and its in-service bit sets. `ppr` reflects the new in-service map from the next cycle. When `dlv_ready` is 1 and `dlv_valid` is 0, nothing changes.
- R7: `irr_pending` is a registered flag. It is 1 after an edge exactly when any request bit remains set after that edge's updates.
- R8: If a request for the same vector arrives in the cycle that the vector is acknowledged, the request bit stays set and the in-service bit also sets.
- R9: An `eoi` pulse clears the highest in-service bit at the clock edge. With nothing in service it has no effect.
- R10: `pic_accept` = `is_bsp` AND (NOT `hw_enable` OR (NOT `lvt0_masked` AND `lvt0_mode` = 3'b111)), where 3'b111 is the external-interrupt delivery mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready, constant 1 |
| req_vector | input | 8 | Requested vector |
| dlv_valid | output | 1 | A vector is deliverable |
| dlv_ready | input | 1 | Core accepts the offered vector |
| dlv_vector | output | 8 | Offered vector |
| eoi | input | 1 | Retire the highest in-service vector |
| tpr | input | 8 | Task priority |
| sw_enable | input | 1 | Software enable |
| hw_enable | input | 1 | Hardware enable |
| is_bsp | input | 1 | This core is the bootstrap core |
| lvt0_masked | input | 1 | Line-0 local vector entry masked |
| lvt0_mode | input | 3 | Line-0 delivery mode |
| ppr | output | 8 | Processor priority |
| irr_pending | output | 1 | Some request bit is set |
| pic_accept | output | 1 | Accept a legacy controller interrupt |

## Verification
The assertions assume that all inputs are synchronous to `clk` and settle before each rising edge. They also assume that `eoi` names no vector, so it always acts on whatever is highest in service. The stimulus changes inputs only on falling edges. It mixes in-range and below-16 request vectors, acknowledges at random (including while nothing is deliverable), and moves `tpr` and the enables both while vectors are in service and while they are not. A bench model of the two bitmaps, written as plain bit arrays, predicts every output on each cycle.

// File: rtl/lapic_pkg.sv
package lapic_pkg;
  // width of the sub-class field that the priority compare ignores
  localparam int SUB_W = 4;
  // line-0 delivery mode that routes the legacy controller to the core
  localparam logic [2:0] LVT_MODE_EXTINT = 3'b111;
endpackage

// File: rtl/lapic_vec_bank.sv
// Bitmap of vectors held as 32-bit words; a set and a clear may hit in one edge, set wins.
module lapic_vec_bank #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [VEC_W-1:0]   set_vec,
  input  logic               clr_en,
  input  logic [VEC_W-1:0]   clr_vec,
  output logic [NUM_VEC-1:0] bits
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int IDX_W     = $clog2(WORD_W);
  localparam int WSEL_W    = VEC_W - IDX_W;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              set_hit;
    logic              clr_hit;

    assign set_hit = set_en && (set_vec[VEC_W-1:IDX_W] == WSEL_W'(w));
    assign clr_hit = clr_en && (clr_vec[VEC_W-1:IDX_W] == WSEL_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else begin
        if (clr_hit) word_q[clr_vec[IDX_W-1:0]] <= 1'b0;
        if (set_hit) word_q[set_vec[IDX_W-1:0]] <= 1'b1;
      end
    end

    assign bits[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/lapic_prio_enc.sv
// Highest-set-bit finder: per-word encoders, then a word-level pick.
module lapic_prio_enc #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] bits,
  output logic               hit,
  output logic [VEC_W-1:0]   top
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int IDX_W     = $clog2(WORD_W);
  localparam int WSEL_W    = VEC_W - IDX_W;

  function automatic logic [IDX_W-1:0] word_top(input logic [WORD_W-1:0] s);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (s[b]) r = IDX_W'(b);
    end
    return r;
  endfunction

  logic [NUM_WORDS-1:0]            word_hit;
  logic [NUM_WORDS-1:0][IDX_W-1:0] word_idx;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_hit[w] = |bits[w*WORD_W +: WORD_W];
    assign word_idx[w] = word_top(bits[w*WORD_W +: WORD_W]);
  end

  always_comb begin
    hit = 1'b0;
    top = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_hit[w]) begin
        hit = 1'b1;
        top = {WSEL_W'(w), word_idx[w]};
      end
    end
  end
endmodule

// File: rtl/lapic_ppr_calc.sv
// Processor priority from task priority and highest in-service vector.
module lapic_ppr_calc
  import lapic_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [VEC_W-1:0] tpr,
  input  logic             isr_hit,
  input  logic [VEC_W-1:0] isr_top,
  output logic [VEC_W-1:0] ppr
);
  logic [VEC_W-1:0] svc;

  always_comb begin
    svc = isr_hit ? isr_top : '0;
    if (tpr[VEC_W-1:SUB_W] >= svc[VEC_W-1:SUB_W]) ppr = tpr;
    else                                           ppr = {svc[VEC_W-1:SUB_W], SUB_W'(0)};
  end
endmodule

// File: rtl/lapic_prio_resolver.sv
module lapic_prio_resolver
  import lapic_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int MIN_VEC = 16,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VEC_W-1:0] req_vector,
  output logic             dlv_valid,
  input  logic             dlv_ready,
  output logic [VEC_W-1:0] dlv_vector,
  input  logic             eoi,
  input  logic [VEC_W-1:0] tpr,
  input  logic             sw_enable,
  input  logic             hw_enable,
  input  logic             is_bsp,
  input  logic             lvt0_masked,
  input  logic [2:0]       lvt0_mode,
  output logic [VEC_W-1:0] ppr,
  output logic             irr_pending,
  output logic             pic_accept
);
  logic [NUM_VEC-1:0] irr_bits;
  logic [NUM_VEC-1:0] isr_bits;
  logic [NUM_VEC-1:0] irr_rest;
  logic               irr_hit;
  logic [VEC_W-1:0]   irr_top;
  logic               isr_hit;
  logic [VEC_W-1:0]   isr_top;
  logic               apic_en;
  logic               req_ok;
  logic               ack;
  logic               pend_q;

  assign req_ready = 1'b1;
  assign req_ok    = req_valid && (req_vector >= VEC_W'(MIN_VEC));
  assign apic_en   = sw_enable && hw_enable;

  lapic_vec_bank #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .VEC_W(VEC_W)) u_irr (
    .clk(clk), .rst_n(rst_n),
    .set_en(req_ok), .set_vec(req_vector),
    .clr_en(ack),    .clr_vec(irr_top),
    .bits(irr_bits)
  );

  lapic_vec_bank #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .VEC_W(VEC_W)) u_isr (
    .clk(clk), .rst_n(rst_n),
    .set_en(ack),           .set_vec(irr_top),
    .clr_en(eoi && isr_hit), .clr_vec(isr_top),
    .bits(isr_bits)
  );

  lapic_prio_enc #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .VEC_W(VEC_W)) u_irr_enc (
    .bits(irr_bits), .hit(irr_hit), .top(irr_top)
  );

  lapic_prio_enc #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .VEC_W(VEC_W)) u_isr_enc (
    .bits(isr_bits), .hit(isr_hit), .top(isr_top)
  );

  lapic_ppr_calc #(.VEC_W(VEC_W)) u_ppr (
    .tpr(tpr), .isr_hit(isr_hit), .isr_top(isr_top), .ppr(ppr)
  );

  // offer only when the request's class strictly beats the processor priority
  assign dlv_valid  = apic_en && irr_hit &&
                      ({irr_top[VEC_W-1:SUB_W], SUB_W'(0)} > ppr);
  assign dlv_vector = irr_top;
  assign ack        = dlv_valid && dlv_ready;

  // what stays requested once the acknowledged vector leaves
  always_comb begin
    irr_rest = irr_bits;
    if (ack) irr_rest[irr_top] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= req_ok || (|irr_rest);
  end
  assign irr_pending = pend_q;

  assign pic_accept = is_bsp &&
                      (!hw_enable || (!lvt0_masked && (lvt0_mode == LVT_MODE_EXTINT)));
endmodule

// File: rtl/lapic_prio_chk.sv
module lapic_prio_chk #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [VEC_W-1:0]   req_vector,
  input logic               dlv_valid,
  input logic               dlv_ready,
  input logic [VEC_W-1:0]   dlv_vector,
  input logic               eoi,
  input logic [VEC_W-1:0]   tpr,
  input logic               sw_enable,
  input logic               hw_enable,
  input logic               is_bsp,
  input logic [VEC_W-1:0]   ppr,
  input logic               irr_pending,
  input logic               pic_accept,
  input logic [NUM_VEC-1:0] irr_bits,
  input logic [NUM_VEC-1:0] isr_bits
);
  p_reset_empty_r1: assert property (@(posedge clk)
    !rst_n |=> (irr_bits == '0) && (isr_bits == '0) && !irr_pending);

  p_no_low_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irr_bits[15:0] == 16'h0);

  p_ppr_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ppr[VEC_W-1:4] >= tpr[VEC_W-1:4]);

  p_dlv_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> ({dlv_vector[VEC_W-1:4], 4'h0} > ppr) && irr_bits[dlv_vector]);

  p_dlv_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> sw_enable && hw_enable);

  p_ack_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && dlv_ready && !(req_valid && req_vector == dlv_vector)
    |=> !irr_bits[$past(dlv_vector)] && isr_bits[$past(dlv_vector)]);

  p_idle_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dlv_valid && !eoi |=> $stable(isr_bits));

  p_pending_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irr_pending == (|irr_bits));

  p_same_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && dlv_ready && req_valid && req_vector == dlv_vector
    |=> irr_bits[$past(dlv_vector)] && isr_bits[$past(dlv_vector)]);

  p_eoi_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && !dlv_valid && (|isr_bits)
    |=> $countones(isr_bits) == $countones($past(isr_bits)) - 1);

  p_pic_bsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pic_accept |-> is_bsp);
endmodule

bind lapic_prio_resolver lapic_prio_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
  .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_vector(dlv_vector),
  .eoi(eoi), .tpr(tpr), .sw_enable(sw_enable), .hw_enable(hw_enable),
  .is_bsp(is_bsp), .ppr(ppr), .irr_pending(irr_pending),
  .pic_accept(pic_accept), .irr_bits(irr_bits), .isr_bits(isr_bits)
);

// File: tb/lapic_prio_resolver_tb.sv
`timescale 1ns/1ps
module lapic_prio_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_vector = 8'h0;
  logic       dlv_valid;
  logic       dlv_ready = 1'b0;
  logic [7:0] dlv_vector;
  logic       eoi = 1'b0;
  logic [7:0] tpr = 8'h35;
  logic       sw_enable = 1'b1;
  logic       hw_enable = 1'b1;
  logic       is_bsp = 1'b1;
  logic       lvt0_masked = 1'b1;
  logic [2:0] lvt0_mode = 3'b000;
  logic [7:0] ppr;
  logic       irr_pending;
  logic       pic_accept;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lapic_prio_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vector(req_vector), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_vector(dlv_vector), .eoi(eoi), .tpr(tpr), .sw_enable(sw_enable),
    .hw_enable(hw_enable), .is_bsp(is_bsp), .lvt0_masked(lvt0_masked),
    .lvt0_mode(lvt0_mode), .ppr(ppr), .irr_pending(irr_pending),
    .pic_accept(pic_accept)
  );

  // behavioural model state
  bit [255:0] m_irr = '0;
  bit [255:0] m_isr = '0;
  bit         m_pend = 0;

  function automatic int hi(input bit [255:0] a);
    for (int i = 255; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic int m_ppr();
    int s = hi(m_isr);
    int t = int'(tpr);
    if (s < 0) s = 0;
    if ((t >> 4) >= (s >> 4)) return t;
    return s & 'hF0;
  endfunction

  function automatic bit m_ok();
    int h = hi(m_irr);
    return sw_enable && hw_enable && (h >= 0) && ((h & 'hF0) > m_ppr());
  endfunction

  function automatic bit m_pic();
    return is_bsp && (!hw_enable || (!lvt0_masked && lvt0_mode == 3'b111));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit ok = m_ok();
    chk("R2 req_ready", int'(req_ready), 1);
    chk("R3 ppr", int'(ppr), m_ppr());
    chk("R4 dlv_valid", int'(dlv_valid), int'(ok));
    if (ok) chk("R4 dlv_vector", int'(dlv_vector), hi(m_irr));
    chk("R7 irr_pending", int'(irr_pending), int'(m_pend));
    chk("R10 pic_accept", int'(pic_accept), int'(m_pic()));
  endtask

  task automatic cycle();
    @(posedge clk);
    if (!rst_n) begin
      m_irr = '0; m_isr = '0; m_pend = 0;
    end else begin
      bit [255:0] ni = m_irr;
      bit [255:0] ns = m_isr;
      int h = hi(m_irr);
      int e = hi(m_isr);
      if (dlv_ready && m_ok()) begin ni[h] = 0; ns[h] = 1; end
      if (eoi && e >= 0) ns[e] = 0;
      if (req_valid && req_vector >= 8'd16) ni[req_vector] = 1;
      m_irr = ni; m_isr = ns; m_pend = |ni;
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cycle();
    rst_n = 1'b1;
    cycle();
    // R1: empty after reset, ppr follows tpr
    chk("R1 irr_pending", int'(irr_pending), 0);
    chk("R1 dlv_valid", int'(dlv_valid), 0);
    chk("R1 ppr", int'(ppr), 'h35);

    // R2: low vector dropped, in-range vector recorded
    tpr = 8'h00;
    req_valid = 1; req_vector = 8'h05; cycle();
    req_valid = 0; cycle();
    chk("R2 low vector dropped", int'(irr_pending), 0);
    req_valid = 1; req_vector = 8'h40; cycle();
    req_valid = 0;
    chk("R2 vector recorded", int'(irr_pending), 1);
    chk("R4 offered", int'(dlv_vector), 'h40);

    // R5: both enables needed
    sw_enable = 0; #1 chk("R5 sw off", int'(dlv_valid), 0);
    sw_enable = 1; hw_enable = 0;
    #1 chk("R5 hw off", int'(dlv_valid), 0);
    chk("R10 hw disabled bsp", int'(pic_accept), 1);
    hw_enable = 1;

    // R3/R4: strict class compare against ppr
    tpr = 8'h45; #1 chk("R4 class below tpr", int'(dlv_valid), 0);
    tpr = 8'h3F; #1 chk("R4 class above tpr", int'(dlv_valid), 1);
    cycle();

    // R6: acknowledge moves the vector
    dlv_ready = 1; cycle(); dlv_ready = 0;
    chk("R6 ppr from isr", int'(ppr), 'h40);
    chk("R6 irr emptied", int'(irr_pending), 0);
    chk("R6 nothing offered", int'(dlv_valid), 0);
    dlv_ready = 1; cycle(); dlv_ready = 0;
    chk("R6 ready alone", int'(ppr), 'h40);

    // R4: equal class blocked, highest across words wins
    req_valid = 1; req_vector = 8'h4A; cycle();
    chk("R4 equal class", int'(dlv_valid), 0);
    req_vector = 8'h51; cycle();
    req_vector = 8'h9F; cycle();
    req_valid = 0;
    chk("R4 cross word", int'(dlv_vector), 'h9F);
    dlv_ready = 1; cycle(); dlv_ready = 0;
    chk("R3 ppr from 9F", int'(ppr), 'h90);
    chk("R4 blocked by ppr", int'(dlv_valid), 0);

    // R9: retire highest in service
    eoi = 1; cycle(); eoi = 0;
    chk("R9 ppr after eoi", int'(ppr), 'h40);
    chk("R9 offered again", int'(dlv_vector), 'h51);

    // R8: same-vector request during acknowledge
    dlv_ready = 1; req_valid = 1; req_vector = 8'h51; cycle();
    dlv_ready = 0; req_valid = 0;
    chk("R8 ppr", int'(ppr), 'h50);
    chk("R8 still pending", int'(irr_pending), 1);
    chk("R8 blocked", int'(dlv_valid), 0);
    eoi = 1; cycle(); eoi = 0;
    chk("R8 vector kept", int'(dlv_vector), 'h51);
    chk("R8 valid again", int'(dlv_valid), 1);

    // R10: legacy accept combinations
    is_bsp = 0; lvt0_masked = 0; lvt0_mode = 3'b111;
    #1 chk("R10 not bsp", int'(pic_accept), 0);
    is_bsp = 1; #1 chk("R10 extint", int'(pic_accept), 1);
    lvt0_masked = 1; #1 chk("R10 masked", int'(pic_accept), 0);
    lvt0_masked = 0; lvt0_mode = 3'b000;
    #1 chk("R10 other mode", int'(pic_accept), 0);
    cycle();

    // random traffic, compared every cycle
    for (int n = 0; n < 4000; n++) begin
      req_valid   = ($urandom % 2) == 0;
      req_vector  = 8'($urandom);
      dlv_ready   = ($urandom % 2) == 0;
      eoi         = ($urandom % 5) == 0;
      if (($urandom % 20) == 0) tpr = 8'($urandom);
      sw_enable   = ($urandom % 20) != 0;
      hw_enable   = ($urandom % 20) != 0;
      is_bsp      = ($urandom % 2) == 0;
      lvt0_masked = ($urandom % 2) == 0;
      lvt0_mode   = 3'($urandom);
      rst_n       = ($urandom % 500) != 0;
      cycle();
    end
    rst_n = 1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule